// File: doc/BRIEF.md
# Twisted Degree-1 Modular Pair Multiplier

This block is a purely combinational datapath for number-theoretic-transform arithmetic in a lattice-based key-encapsulation scheme. It takes two coefficient pairs, one from each operand polynomial: the even-indexed coefficient `2k` and the odd-indexed coefficient `2k+1`. Each pair is read as a linear polynomial, `lo + hi·X`. The block forms their product modulo `(X² − zeta)`, where zeta is the twiddle for pair number k (0 to 127). It then reduces both result coefficients modulo the prime q = 3329 using Barrett reduction.

A surrounding sequencer reads the two pairs, looks up the twiddle for the pair index and presents all five 12-bit values on the inputs. It registers the two 12-bit results on the next clock edge. The block contains the partial-product multipliers, the adders and three Barrett reducers. Storage, sequencing, handshakes and the twiddle table belong to the caller.

Top module: `twisted_pair_mul`

## Requirements
- R1: With all inputs in [0, 3328], `c0_o` equals `(a0·b0 + ((a1·b1) mod 3329)·zeta) mod 3329`.
- R2: With all inputs in [0, 3328], `c1_o` equals `(a0·b1 + a1·b0) mod 3329`.
- R3: Both outputs are always fully reduced, in [0, 3328]; each Barrett stage needs at most one conditional subtraction of 3329.
- R4: The outputs depend only on the present inputs, with no clock or state. A new operand set presented every cycle yields its own result before the next edge.
- R5: When `zeta_i` is 0, `c0_o` equals `(a0·b0) mod 3329`.
- R6: `c1_o` does not depend on `zeta_i`. Changing only zeta leaves `c1_o` unchanged.
- R7: Operands at their maximum (all inputs 3328) cause no overflow. The cross-term sum reaches 2·3328² and gives `c1_o` = 2. `c0_o` = 0 for zeta 3328 and 1 for zeta 0.
- R8: All-zero inputs give `c0_o` = 0 and `c1_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a0_i | input | 12 | Even-indexed coefficient of the first operand |
| a1_i | input | 12 | Odd-indexed coefficient of the first operand |
| b0_i | input | 12 | Even-indexed coefficient of the second operand |
| b1_i | input | 12 | Odd-indexed coefficient of the second operand |
| zeta_i | input | 12 | Twiddle for this pair, supplied by the caller |
| c0_o | output | 12 | Constant coefficient of the reduced product |
| c1_o | output | 12 | Linear coefficient of the reduced product |

## Verification
Both result coefficients settle in the same cycle from shared operands. The twisted path (odd product, first reduction, zeta scaling, second reduction) and the cross-term path each end in their own reducer. The bench provokes the two paths together by sweeping only the twiddle while the coefficient pairs stay fixed. It also drives every input to 3328 so that both reducers see their widest sums at once. A scoreboard model built on the `%` operator judges each output in the cycle its operands were applied. It expects `c0_o` to track zeta and `c1_o` to hold still.

// File: rtl/bcm_pkg.sv
package bcm_pkg;

    localparam int unsigned COEF_W   = 12;
    localparam int unsigned MOD_Q    = 3329;
    localparam int unsigned PROD_W   = 2 * COEF_W;
    localparam int unsigned SUM_W    = PROD_W + 1;
    localparam int unsigned NUM_PROD = 4;

    typedef logic [COEF_W-1:0] coef_t;
    typedef logic [PROD_W-1:0] prod_t;
    typedef logic [SUM_W-1:0]  sum_t;

    // one degree-1 polynomial: lo + hi*X
    typedef struct packed {
        coef_t lo;
        coef_t hi;
    } pair_t;

    // the four partial products of a pair-by-pair multiply
    typedef struct packed {
        prod_t even;     // lo*lo
        prod_t odd;      // hi*hi
        prod_t cross_a;  // lo_a*hi_b
        prod_t cross_b;  // hi_a*lo_b
    } prod_set_t;

    // floor(2^k / q) for a Barrett stage
    function automatic longint unsigned barrett_const(input int unsigned k,
                                                      input int unsigned q);
        return (64'd1 << k) / longint'(q);
    endfunction

endpackage

// File: rtl/bcm_mult.sv
module bcm_mult #(
    parameter int unsigned A_W = 12,
    parameter int unsigned B_W = 12
) (
    input  logic [A_W-1:0]     a_i,
    input  logic [B_W-1:0]     b_i,
    output logic [A_W+B_W-1:0] p_o
);
    localparam int unsigned P_W = A_W + B_W;

    always_comb begin
        p_o = P_W'(a_i) * P_W'(b_i);
        if (a_i == '0 || b_i == '0) begin
            AST_MUL_ZERO: assert (p_o == '0);  // R8
        end
        if (b_i != '0) begin
            AST_MUL_NO_WRAP: assert ((p_o / P_W'(b_i)) == P_W'(a_i) && (p_o % P_W'(b_i)) == '0);  // R7
        end
    end

endmodule

// File: rtl/bcm_partials.sv
module bcm_partials
    import bcm_pkg::*;
(
    input  pair_t     a_i,
    input  pair_t     b_i,
    output prod_set_t prods_o
);
    coef_t lhs  [NUM_PROD];
    coef_t rhs  [NUM_PROD];
    prod_t prod [NUM_PROD];

    // slot order: even, odd, cross_a, cross_b
    always_comb begin
        lhs[0] = a_i.lo;  rhs[0] = b_i.lo;
        lhs[1] = a_i.hi;  rhs[1] = b_i.hi;
        lhs[2] = a_i.lo;  rhs[2] = b_i.hi;
        lhs[3] = a_i.hi;  rhs[3] = b_i.lo;
    end

    for (genvar g = 0; g < NUM_PROD; g++) begin : g_mul
        bcm_mult #(
            .A_W (COEF_W),
            .B_W (COEF_W)
        ) u_mul (
            .a_i (lhs[g]),
            .b_i (rhs[g]),
            .p_o (prod[g])
        );
    end

    always_comb begin
        prods_o.even    = prod[0];
        prods_o.odd     = prod[1];
        prods_o.cross_a = prod[2];
        prods_o.cross_b = prod[3];
    end

endmodule

// File: rtl/bcm_barrett.sv
module bcm_barrett #(
    parameter int unsigned IN_W  = 25,
    parameter int unsigned Q     = 3329,
    parameter int unsigned OUT_W = 12
) (
    input  logic [IN_W-1:0]  x_i,
    output logic [OUT_W-1:0] r_o
);
    // With k = IN_W the estimate undershoots floor(x/q) by at most one,
    // so the remainder lands in [0, 2q) and one subtraction suffices.
    localparam int unsigned     SHIFT_K = IN_W;
    localparam longint unsigned MU      = bcm_pkg::barrett_const(SHIFT_K, Q);
    localparam int unsigned     MU_W    = $clog2(MU + 1);
    localparam int unsigned     EST_W   = IN_W + MU_W;
    localparam logic [MU_W-1:0] MU_C    = MU_W'(MU);
    localparam logic [IN_W-1:0] Q_IN    = IN_W'(Q);

    logic [EST_W-1:0] est_full;
    logic [MU_W-1:0]  quot;
    logic [IN_W-1:0]  quot_q;
    logic [IN_W-1:0]  rem;

    always_comb begin
        est_full = EST_W'(x_i) * EST_W'(MU_C);
        quot     = est_full[EST_W-1:SHIFT_K];
        quot_q   = IN_W'(quot) * Q_IN;
        rem      = x_i - quot_q;
        if (rem >= Q_IN) begin
            r_o = OUT_W'(rem - Q_IN);
        end else begin
            r_o = OUT_W'(rem);
        end
        AST_ONE_SUBTRACT: assert (rem < 2 * Q_IN);                  // R3
        AST_REDUCED:      assert (IN_W'(r_o) < Q_IN);               // R3
        AST_RESIDUE:      assert (IN_W'(r_o) == (x_i % Q_IN));      // R1
    end

endmodule

// File: rtl/twisted_pair_mul.sv
module twisted_pair_mul
    import bcm_pkg::*;
(
    input  logic [11:0] a0_i,
    input  logic [11:0] a1_i,
    input  logic [11:0] b0_i,
    input  logic [11:0] b1_i,
    input  logic [11:0] zeta_i,
    output logic [11:0] c0_o,
    output logic [11:0] c1_o
);
    pair_t     pa;
    pair_t     pb;
    prod_set_t prods;
    coef_t     odd_red;
    prod_t     twisted;
    sum_t      even_sum;
    sum_t      cross_sum;

    always_comb begin
        pa.lo = a0_i;
        pa.hi = a1_i;
        pb.lo = b0_i;
        pb.hi = b1_i;
    end

    bcm_partials u_partials (
        .a_i     (pa),
        .b_i     (pb),
        .prods_o (prods)
    );

    // hi*hi is reduced before scaling so the twisted term stays 24 bits
    bcm_barrett #(
        .IN_W  (PROD_W),
        .Q     (MOD_Q),
        .OUT_W (COEF_W)
    ) u_red_odd (
        .x_i (prods.odd),
        .r_o (odd_red)
    );

    bcm_mult #(
        .A_W (COEF_W),
        .B_W (COEF_W)
    ) u_twist (
        .a_i (odd_red),
        .b_i (zeta_i),
        .p_o (twisted)
    );

    always_comb begin
        even_sum  = SUM_W'(prods.even) + SUM_W'(twisted);
        cross_sum = SUM_W'(prods.cross_a) + SUM_W'(prods.cross_b);
    end

    bcm_barrett #(
        .IN_W  (SUM_W),
        .Q     (MOD_Q),
        .OUT_W (COEF_W)
    ) u_red_c0 (
        .x_i (even_sum),
        .r_o (c0_o)
    );

    bcm_barrett #(
        .IN_W  (SUM_W),
        .Q     (MOD_Q),
        .OUT_W (COEF_W)
    ) u_red_c1 (
        .x_i (cross_sum),
        .r_o (c1_o)
    );

endmodule

// File: tb/twisted_pair_mul_bench.sv
module twisted_pair_mul_bench;
    import bcm_pkg::*;

    localparam int unsigned QV = 3329;

    logic  clk = 1'b0;
    logic  rst = 1'b1;
    always #2.5 clk = ~clk;

    coef_t a0 = '0, a1 = '0, b0 = '0, b1 = '0, zt = '0;
    coef_t c0, c1;

    twisted_pair_mul u_twisted_pair_mul (
        .a0_i (a0), .a1_i (a1), .b0_i (b0), .b1_i (b1), .zeta_i (zt),
        .c0_o (c0), .c1_o (c1)
    );

    int    checks   = 0;
    int    failures = 0;
    logic  done     = 1'b0;

    coef_t exp_c0_q [$];
    coef_t exp_c1_q [$];
    string tag_c0_q [$];
    string tag_c1_q [$];

    function automatic coef_t model_c0(int unsigned x0, int unsigned x1,
                                       int unsigned y0, int unsigned y1, int unsigned z);
        longint unsigned t;
        t = ((longint'(x1) * y1) % QV) * z + longint'(x0) * y0;
        return coef_t'(t % QV);
    endfunction

    function automatic coef_t model_c1(int unsigned x0, int unsigned x1,
                                       int unsigned y0, int unsigned y1);
        longint unsigned t;
        t = longint'(x0) * y1 + longint'(x1) * y0;
        return coef_t'(t % QV);
    endfunction

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // driver: applies operands just after a rising edge and queues the expectation
    task automatic drive(input int unsigned x0, input int unsigned x1, input int unsigned y0,
                         input int unsigned y1, input int unsigned z,
                         input string t0, input string t1);
        @(posedge clk);
        #1;
        a0 = coef_t'(x0); a1 = coef_t'(x1); b0 = coef_t'(y0); b1 = coef_t'(y1); zt = coef_t'(z);
        exp_c0_q.push_back(model_c0(x0, x1, y0, y1, z));
        exp_c1_q.push_back(model_c1(x0, x1, y0, y1));
        tag_c0_q.push_back(t0);
        tag_c1_q.push_back(t1);
    endtask

    // monitor: judges the combinational result in the same cycle, at the falling edge
    always @(negedge clk) begin
        if (!rst && exp_c0_q.size() > 0) begin
            coef_t e0, e1;
            string s0, s1;
            e0 = exp_c0_q.pop_front();
            e1 = exp_c1_q.pop_front();
            s0 = tag_c0_q.pop_front();
            s1 = tag_c1_q.pop_front();
            check(s0, int'(c0), int'(e0));
            check(s1, int'(c1), int'(e1));
            check("R3 c0 range", int'(c0 < coef_t'(QV)), 1);
            check("R3 c1 range", int'(c1 < coef_t'(QV)), 1);
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_run();
        end
    end

    initial begin : stim
        int unsigned ra0, ra1, rb0, rb1;
        repeat (3) @(posedge clk);
        #1;
        // R8 reset state: zero operands give zero outputs before any traffic
        @(negedge clk);
        check("R8 reset c0", int'(c0), 0);
        check("R8 reset c1", int'(c1), 0);
        rst = 1'b0;

        drive(0, 0, 0, 0, 0, "R8 zero c0", "R8 zero c1");
        drive(0, 0, 0, 0, QV - 1, "R8 zero zeta-max c0", "R8 zero zeta-max c1");

        // R7 extremes: expected c0=0, c1=2 with zeta 3328; c0=1 with zeta 0
        drive(QV - 1, QV - 1, QV - 1, QV - 1, QV - 1, "R7 max c0", "R7 max c1");
        drive(QV - 1, QV - 1, QV - 1, QV - 1, 0, "R7 R5 max zeta0 c0", "R7 max zeta0 c1");

        // R5 zeta zero
        for (int i = 0; i < 20; i++) begin
            drive($urandom % QV, $urandom % QV, $urandom % QV, $urandom % QV, 0,
                  "R5 zeta0 c0", "R2 zeta0 c1");
        end

        // R6 sweep only zeta with fixed pairs
        for (int j = 0; j < 10; j++) begin
            ra0 = $urandom % QV; ra1 = $urandom % QV; rb0 = $urandom % QV; rb1 = $urandom % QV;
            drive(ra0, ra1, rb0, rb1, 0,      "R1 sweep c0", "R6 sweep c1");
            drive(ra0, ra1, rb0, rb1, 1,      "R1 sweep c0", "R6 sweep c1");
            drive(ra0, ra1, rb0, rb1, QV - 1, "R1 sweep c0", "R6 sweep c1");
            drive(ra0, ra1, rb0, rb1, $urandom % QV, "R1 sweep c0", "R6 sweep c1");
        end

        // R4 alternating vectors every cycle
        for (int k = 0; k < 20; k++) begin
            if (k % 2 == 0) drive(QV - 1, 1, 2, QV - 1, 17, "R4 alt c0", "R4 alt c1");
            else            drive(5, QV - 2, QV - 1, 0, QV - 1, "R4 alt c0", "R4 alt c1");
        end

        // R1 R2 random back-to-back
        for (int m = 0; m < 300; m++) begin
            drive($urandom % QV, $urandom % QV, $urandom % QV, $urandom % QV, $urandom % QV,
                  "R1 random c0", "R2 random c1");
        end

        repeat (3) @(posedge clk);
        check("R4 queue drained", exp_c0_q.size(), 0);
        done = 1'b1;
        finish_run();
    end

endmodule